// File: doc/BRIEF.md
# DRAM Access Issue Scheduler

This block sits between a single in-order request port and a shared DRAM data bus. It accepts one read or write request per cycle. It splits the physical address into a DIMM, a rank and a bank, and it scatters bank numbers by folding low row bits into the bank field with XOR. It then decides the cycle in which the held request may start on the bus.

Two rules gate each start. The first rule applies to the target bank. After an access starts, that bank stays occupied for a run-time number of cycles. Accesses to other banks may start in the meantime. The second rule applies to the data bus. When the bus changes direction or moves to another DIMM, the bus must stay idle for a run-time number of cycles. One case is selectable: back-to-back writes that move between DIMMs either pay this idle gap or skip it. A mode input chooses which.

The block holds one request and does not reorder requests. When the held request cannot start, the ready output drops to 0 and holds the next request back.

Top module: `dram_issue_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready_o` is 1 and `iss_valid_o` is 0.
- R2: A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both 1, and it goes into a one-entry holding slot. `req_ready_o` is 0 in exactly those cycles where the slot is full and its request does not issue. Requests issue in the order in which they were accepted.
- R3: If nothing blocks it, an accepted request issues in the cycle after acceptance. The issue reports the direction (1 = write) together with the decoded DIMM, rank and bank.
- R4: The address is decoded with the default widths as follows. The DIMM is bits [11:10] and the rank is bits [9:8]. The bank is bits [7:6] XOR bits [13:12].
- R5: A bank is identified by the triple (DIMM, rank, bank). Suppose a bank issues in cycle t while `busy_cycles_i` = B. The next issue to that same bank is then no earlier than cycle t+B+1. Issues to other banks are not held back by this.
- R6: If an issue changes direction from the previous issue, either read to write or write to read, at least `turn_cycles_i` cycles without an issue must lie between the two issues.
- R7: If an issue targets a different DIMM than the previous issue, the same idle gap is required. The one exception is when both issues are writes and `wr_gap_en_i` is 0.
- R8: Issues to free banks with the same direction and the same DIMM may follow in consecutive cycles.
- R9: When `wr_gap_en_i` is 1, a write that follows a write to a different DIMM waits for the turnaround gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_gap_en_i | input | 1 | 1: writes that switch DIMM need the turnaround gap |
| busy_cycles_i | input | 6 | Number of cycles a bank stays occupied after an issue |
| turn_cycles_i | input | 6 | Number of idle bus cycles required for a turnaround |
| req_valid_i | input | 1 | A request is offered |
| req_write_i | input | 1 | Request direction, 1 = write |
| req_addr_i | input | 32 | Physical address of the request |
| req_ready_o | output | 1 | The block can take a request in this cycle |
| iss_valid_o | output | 1 | The held request starts on the bus in this cycle |
| iss_write_o | output | 1 | Direction of the issued access |
| iss_dimm_o | output | 2 | DIMM of the issued access |
| iss_rank_o | output | 2 | Rank of the issued access |
| iss_bank_o | output | 2 | Bank of the issued access after the XOR mapping |

## Verification
An unblocked request is due on the issue port exactly one cycle after the edge that accepted it. A blocked request is due at a later cycle: the latest of the cycle after acceptance, the cycle the target bank frees (issue + B + 1), and the cycle the bus gap ends (previous issue + turnaround + 1). For each accepted request the driver computes this cycle from the requirements and stores it in the scoreboard. The monitor samples at the falling edge and compares both the cycle and the target. While a request waits, the driver also compares `req_ready_o` every cycle against the cycle in which the previous request is due to issue.

// File: rtl/dram_sched_pkg.sv
package dram_sched_pkg;
  localparam int unsigned DEF_ADDR_W = 32;
  localparam int unsigned DEF_DIMM_W = 2;
  localparam int unsigned DEF_RANK_W = 2;
  localparam int unsigned DEF_BANK_W = 2;
  localparam int unsigned DEF_COL_W  = 6;
  localparam int unsigned DEF_CNT_W  = 6;

  typedef enum logic {DIR_RD = 1'b0, DIR_WR = 1'b1} dir_e;
endpackage

// File: rtl/dram_addr_map.sv
module dram_addr_map #(
  parameter int unsigned ADDR_W = dram_sched_pkg::DEF_ADDR_W,
  parameter int unsigned DIMM_W = dram_sched_pkg::DEF_DIMM_W,
  parameter int unsigned RANK_W = dram_sched_pkg::DEF_RANK_W,
  parameter int unsigned BANK_W = dram_sched_pkg::DEF_BANK_W,
  parameter int unsigned COL_W  = dram_sched_pkg::DEF_COL_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DIMM_W-1:0] dimm_o,
  output logic [RANK_W-1:0] rank_o,
  output logic [BANK_W-1:0] bank_o
);
  localparam int unsigned BANK_LSB = COL_W;
  localparam int unsigned RANK_LSB = BANK_LSB + BANK_W;
  localparam int unsigned DIMM_LSB = RANK_LSB + RANK_W;
  localparam int unsigned ROW_LSB  = DIMM_LSB + DIMM_W;

  assign dimm_o = addr_i[DIMM_LSB +: DIMM_W];
  assign rank_o = addr_i[RANK_LSB +: RANK_W];
  // fold low row bits into the bank field to scatter rows across banks
  assign bank_o = addr_i[BANK_LSB +: BANK_W] ^ addr_i[ROW_LSB +: BANK_W];
endmodule

// File: rtl/dram_bank_tracker.sv
module dram_bank_tracker #(
  parameter int unsigned ID_W  = 6,
  parameter int unsigned CNT_W = dram_sched_pkg::DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [ID_W-1:0]  set_id_i,
  input  logic [CNT_W-1:0] busy_cycles_i,
  input  logic [ID_W-1:0]  qry_id_i,
  output logic             free_o
);
  localparam int unsigned NUM_BANKS = 1 << ID_W;

  logic [NUM_BANKS-1:0] busy_vec;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
      end else if (set_i && (set_id_i == ID_W'(g))) begin
        cnt_q <= busy_cycles_i;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
    assign busy_vec[g] = (cnt_q != '0);
  end

  assign free_o = ~busy_vec[qry_id_i];
endmodule

// File: rtl/dram_turn_guard.sv
module dram_turn_guard #(
  parameter int unsigned DIMM_W = dram_sched_pkg::DEF_DIMM_W,
  parameter int unsigned CNT_W  = dram_sched_pkg::DEF_CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_gap_en_i,
  input  logic [CNT_W-1:0]  turn_cycles_i,
  input  logic              cand_write_i,
  input  logic [DIMM_W-1:0] cand_dimm_i,
  input  logic              iss_i,
  output logic              ok_o
);
  logic              last_vld_q;
  logic              last_wr_q;
  logic [DIMM_W-1:0] last_dimm_q;
  logic [CNT_W-1:0]  idle_q;
  logic              dir_chg;
  logic              dimm_chg;
  logic              wr_stream;
  logic              need_gap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_vld_q  <= 1'b0;
      last_wr_q   <= 1'b0;
      last_dimm_q <= '0;
      idle_q      <= '0;
    end else if (iss_i) begin
      last_vld_q  <= 1'b1;
      last_wr_q   <= cand_write_i;
      last_dimm_q <= cand_dimm_i;
      idle_q      <= '0;
    end else if (idle_q != '1) begin
      idle_q <= idle_q + 1'b1;
    end
  end

  assign dir_chg   = last_wr_q != cand_write_i;
  assign dimm_chg  = last_dimm_q != cand_dimm_i;
  // write-to-write DIMM switch skips the gap under static termination
  assign wr_stream = last_wr_q & cand_write_i & ~wr_gap_en_i;
  assign need_gap  = last_vld_q & (dir_chg | (dimm_chg & ~wr_stream));
  assign ok_o      = ~need_gap | (idle_q >= turn_cycles_i);
endmodule

// File: rtl/dram_issue_sched.sv
module dram_issue_sched #(
  parameter int unsigned ADDR_W = dram_sched_pkg::DEF_ADDR_W,
  parameter int unsigned DIMM_W = dram_sched_pkg::DEF_DIMM_W,
  parameter int unsigned RANK_W = dram_sched_pkg::DEF_RANK_W,
  parameter int unsigned BANK_W = dram_sched_pkg::DEF_BANK_W,
  parameter int unsigned COL_W  = dram_sched_pkg::DEF_COL_W,
  parameter int unsigned CNT_W  = dram_sched_pkg::DEF_CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_gap_en_i,
  input  logic [CNT_W-1:0]  busy_cycles_i,
  input  logic [CNT_W-1:0]  turn_cycles_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              iss_valid_o,
  output logic              iss_write_o,
  output logic [DIMM_W-1:0] iss_dimm_o,
  output logic [RANK_W-1:0] iss_rank_o,
  output logic [BANK_W-1:0] iss_bank_o
);
  import dram_sched_pkg::*;

  localparam int unsigned ID_W = DIMM_W + RANK_W + BANK_W;

  logic              hold_vld_q;
  dir_e              hold_dir_q;
  logic [ADDR_W-1:0] hold_addr_q;
  logic [DIMM_W-1:0] dec_dimm;
  logic [RANK_W-1:0] dec_rank;
  logic [BANK_W-1:0] dec_bank;
  logic [ID_W-1:0]   bank_id;
  logic              bank_free;
  logic              bus_ok;
  logic              fire;
  logic              accept;

  dram_addr_map #(
    .ADDR_W(ADDR_W), .DIMM_W(DIMM_W), .RANK_W(RANK_W),
    .BANK_W(BANK_W), .COL_W(COL_W)
  ) i_map (
    .addr_i(hold_addr_q),
    .dimm_o(dec_dimm),
    .rank_o(dec_rank),
    .bank_o(dec_bank)
  );

  assign bank_id = {dec_dimm, dec_rank, dec_bank};

  dram_bank_tracker #(.ID_W(ID_W), .CNT_W(CNT_W)) i_banks (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .set_i        (fire),
    .set_id_i     (bank_id),
    .busy_cycles_i(busy_cycles_i),
    .qry_id_i     (bank_id),
    .free_o       (bank_free)
  );

  dram_turn_guard #(.DIMM_W(DIMM_W), .CNT_W(CNT_W)) i_turn (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_gap_en_i  (wr_gap_en_i),
    .turn_cycles_i(turn_cycles_i),
    .cand_write_i (hold_dir_q == DIR_WR),
    .cand_dimm_i  (dec_dimm),
    .iss_i        (fire),
    .ok_o         (bus_ok)
  );

  assign fire        = hold_vld_q & bank_free & bus_ok;
  assign req_ready_o = ~hold_vld_q | fire;
  assign accept      = req_valid_i & req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_vld_q  <= 1'b0;
      hold_dir_q  <= DIR_RD;
      hold_addr_q <= '0;
    end else if (accept) begin
      hold_vld_q  <= 1'b1;
      hold_dir_q  <= req_write_i ? DIR_WR : DIR_RD;
      hold_addr_q <= req_addr_i;
    end else if (fire) begin
      hold_vld_q <= 1'b0;
    end
  end

  assign iss_valid_o = fire;
  assign iss_write_o = hold_dir_q == DIR_WR;
  assign iss_dimm_o  = dec_dimm;
  assign iss_rank_o  = dec_rank;
  assign iss_bank_o  = dec_bank;
endmodule

// File: rtl/dram_issue_sched_chk.sv
module dram_issue_sched_chk #(
  parameter int unsigned DIMM_W = 2,
  parameter int unsigned RANK_W = 2,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned CNT_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_gap_en_i,
  input logic [CNT_W-1:0]  busy_cycles_i,
  input logic [CNT_W-1:0]  turn_cycles_i,
  input logic              iss_valid_o,
  input logic              iss_write_o,
  input logic [DIMM_W-1:0] iss_dimm_o,
  input logic [RANK_W-1:0] iss_rank_o,
  input logic [BANK_W-1:0] iss_bank_o
);
  a_r3_issue_known: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_o |-> !$isunknown({iss_write_o, iss_dimm_o, iss_rank_o, iss_bank_o}));

  a_r5_bank_no_repeat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_o && busy_cycles_i != '0) |=>
      !(iss_valid_o && iss_dimm_o == $past(iss_dimm_o) &&
        iss_rank_o == $past(iss_rank_o) && iss_bank_o == $past(iss_bank_o)));

  a_r6_dir_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_o && turn_cycles_i != '0) |=>
      !(iss_valid_o && iss_write_o != $past(iss_write_o)));

  a_r7_dimm_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_o && turn_cycles_i != '0) |=>
      !(iss_valid_o && iss_dimm_o != $past(iss_dimm_o) &&
        !(iss_write_o && $past(iss_write_o) && !wr_gap_en_i)));

  a_r9_wr_switch_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_o && iss_write_o && wr_gap_en_i && turn_cycles_i != '0) |=>
      !(iss_valid_o && iss_write_o && wr_gap_en_i &&
        iss_dimm_o != $past(iss_dimm_o)));
endmodule

bind dram_issue_sched dram_issue_sched_chk #(
  .DIMM_W(DIMM_W), .RANK_W(RANK_W), .BANK_W(BANK_W), .CNT_W(CNT_W)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_gap_en_i  (wr_gap_en_i),
  .busy_cycles_i(busy_cycles_i),
  .turn_cycles_i(turn_cycles_i),
  .iss_valid_o  (iss_valid_o),
  .iss_write_o  (iss_write_o),
  .iss_dimm_o   (iss_dimm_o),
  .iss_rank_o   (iss_rank_o),
  .iss_bank_o   (iss_bank_o)
);

// File: tb/test_dram_issue_sched.sv
module test_dram_issue_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_gap_en = 1'b0;
  logic [5:0]  busy_cyc = 6'd5;
  logic [5:0]  turn_cyc = 6'd2;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready;
  logic        iss_valid;
  logic        iss_write;
  logic [1:0]  iss_dimm;
  logic [1:0]  iss_rank;
  logic [1:0]  iss_bank;

  always #5 clk = ~clk;

  dram_issue_sched i_dram_issue_sched (
    .clk_i(clk), .rst_ni(rst_n), .wr_gap_en_i(wr_gap_en),
    .busy_cycles_i(busy_cyc), .turn_cycles_i(turn_cyc),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_ready_o(req_ready), .iss_valid_o(iss_valid), .iss_write_o(iss_write),
    .iss_dimm_o(iss_dimm), .iss_rank_o(iss_rank), .iss_bank_o(iss_bank)
  );

  typedef struct {
    logic   w;
    int     d;
    int     r;
    int     b;
    longint c;
    string  tag;
  } exp_t;

  exp_t   sb[$];
  int     n_run = 0;
  int     n_fail = 0;
  longint cyc = 0;
  bit     done = 1'b0;

  // bench-side model state
  longint bank_free[64];
  longint last_iss = 0;
  longint prev_iss = 0;
  bit     last_v = 1'b0;
  logic   last_w = 1'b0;
  int     last_d = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic longint lmax(input longint a, input longint b);
    return (a > b) ? a : b;
  endfunction

  // monitor: pop and compare on every issue
  always @(negedge clk) begin
    if (rst_n && iss_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R2", "unexpected issue", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(cyc == e.c, e.tag, "issue cycle", cyc, e.c);
        chk(iss_write == e.w, e.tag, "direction", iss_write, e.w);
        chk(iss_dimm == 2'(e.d), e.tag, "dimm", iss_dimm, e.d);
        chk(iss_rank == 2'(e.r), e.tag, "rank", iss_rank, e.r);
        chk(iss_bank == 2'(e.b), e.tag, "bank", iss_bank, e.b);
      end
    end
  end

  // driver: called positioned at a falling edge
  task automatic send(input logic w, input int d, input int r, input int nb,
                      input int row, input string tag);
    exp_t   e;
    longint a;
    longint t;
    int     b;
    int     id;
    bit     need;
    req_valid = 1'b1;
    req_write = w;
    req_addr  = (32'(row) << 12) | (32'(d) << 10) | (32'(r) << 8) | (32'(nb) << 6);
    forever begin
      chk(req_ready == (cyc >= prev_iss), "R2", "ready", req_ready, cyc >= prev_iss);
      if (req_ready) break;
      @(negedge clk);
    end
    a = cyc;
    b = nb ^ (row & 3);
    id = d * 16 + r * 4 + b;
    t = a + 1;
    need = last_v && ((last_w != w) || ((last_d != d) && !(last_w && w && !wr_gap_en)));
    if (need) t = lmax(t, last_iss + longint'(turn_cyc) + 1);
    t = lmax(t, bank_free[id]);
    bank_free[id] = t + longint'(busy_cyc) + 1;
    last_iss = t;
    prev_iss = t;
    last_v = 1'b1;
    last_w = w;
    last_d = d;
    e.w = w; e.d = d; e.r = r; e.b = b; e.c = t; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) bank_free[i] = 0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    chk(iss_valid == 1'b0, "R1", "issue in reset", iss_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(iss_valid == 1'b0, "R1", "issue after reset", iss_valid, 0);

    // R3 R8: one DIMM, reads to four free banks in consecutive cycles
    for (int k = 0; k < 4; k++) send(1'b0, 0, 0, k, 0, "R8");
    drain();
    // R5: same bank twice
    send(1'b0, 0, 0, 0, 0, "R5");
    send(1'b0, 0, 0, 0, 0, "R5");
    drain();
    // R4: the row bits remap the bank, so the first two do not collide and the third does
    send(1'b0, 0, 1, 1, 0, "R4");
    send(1'b0, 0, 1, 1, 1, "R4");
    send(1'b0, 0, 1, 0, 1, "R4");
    drain();
    // R6: read to write, then write to read
    send(1'b0, 1, 0, 0, 0, "R6");
    send(1'b1, 1, 0, 1, 0, "R6");
    send(1'b0, 1, 0, 2, 0, "R6");
    drain();
    // R7: DIMM switch on reads
    send(1'b0, 0, 2, 2, 0, "R7");
    send(1'b0, 2, 2, 2, 0, "R7");
    drain();
    // R7: a write stream across DIMMs with static termination has no gap
    send(1'b1, 0, 3, 0, 0, "R7");
    send(1'b1, 3, 3, 0, 0, "R7");
    drain();
    // R9: a write stream across DIMMs with switched termination needs the gap
    wr_gap_en = 1'b1;
    send(1'b1, 0, 3, 1, 0, "R9");
    send(1'b1, 3, 3, 1, 0, "R9");
    send(1'b1, 1, 3, 1, 0, "R9");
    drain();
    // R5: a busy time of zero allows back-to-back issues to one bank
    busy_cyc = 6'd0;
    send(1'b0, 2, 1, 3, 0, "R5");
    send(1'b0, 2, 1, 3, 0, "R5");
    drain();
    // R6: a longer turnaround, with R2 ready held low across the gap
    turn_cyc = 6'd4;
    busy_cyc = 6'd3;
    send(1'b0, 1, 1, 0, 2, "R6");
    send(1'b1, 1, 1, 1, 2, "R6");
    send(1'b1, 1, 1, 1, 2, "R2");
    send(1'b0, 2, 0, 0, 3, "R2");
    drain();
    chk(sb.size() == 0, "R2", "pending issues", sb.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule